// File: doc/BRIEF.md
# Transceiver Enable and Power-Down Sequencer

This block decides when the receive and transmit data paths of a burst transceiver run and when they are held in reset. Each path has two enable sources, an external pin and a bit in a control register. A path is enabled when either source is high. Each path has its own clock. The combined enable of each path is brought into that clock domain through a synchroniser. All path state changes on that clock.

When the receiver's enable falls, the receive path goes into reset at once. A flush sequence then runs for a fixed number of receive clocks, six by default. It runs to the end even if the enable comes back during it. On the first cycle of the flush, a one-cycle clear strobe goes to the receiver's test-output select register. That register is the only control register that power-down touches. When the receiver comes back, reset releases and a one-cycle acquisition request is sent, so reception always restarts in acquisition mode. The transmit path works the same way with a one-cycle flush and a start strobe. The oscillator enable bit passes straight through and does not depend on either path.

The ports are plain control and status levels and strobes. No data crosses this block, so it has no valid/ready interface and no back-pressure.

Top module: `xcvr_pwr_seq`

## Requirements
- R1: The receive path is enabled when rx_en_pin OR rx_en_reg is high. With both inputs low, rx_path_rst stays high.
- R2: The transmit path is enabled when tx_en_pin OR tx_en_reg is high. With both inputs low, tx_path_rst stays high.
- R3: An enable change passes through a two-stage synchroniser. The path outputs react on the third rising edge of that path's clock after the change.
- R4: When the receive enable falls, rx_path_rst and rx_flush both rise on the same edge. rx_flush stays high for exactly RX_SEQ_LEN (6) receive clocks.
- R5: While a path stays disabled, its path reset stays high after the flush ends.
- R6: tst_sel_clr is a one-cycle pulse in the first flush cycle of the receive path. A transmit shutdown never produces it.
- R7: On receive re-enable, rx_path_rst falls and rx_acq_req pulses for one cycle on the same edge. If the enable rises during a flush, the flush still completes. Release then happens at the end of the flush, or three edges after the rise, whichever is later.
- R8: When the transmit enable falls, tx_path_rst rises and tx_flush pulses for one transmit clock. On re-enable, tx_path_rst falls and tx_start pulses for one cycle.
- R9: osc_run equals osc_en_reg at all times, whatever the path enables.
- R10: While rst_n is low, both path resets are high and rx_flush, tx_flush, tst_sel_clr, rx_acq_req and tx_start are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive path clock |
| tx_clk | input | 1 | Transmit path clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en_pin | input | 1 | Receive enable pin |
| rx_en_reg | input | 1 | Receive enable register bit |
| tx_en_pin | input | 1 | Transmit enable pin |
| tx_en_reg | input | 1 | Transmit enable register bit |
| osc_en_reg | input | 1 | Oscillator enable register bit |
| rx_path_rst | output | 1 | Receive datapath reset, high while disabled or flushing |
| rx_flush | output | 1 | Receive flush sequence in progress |
| tst_sel_clr | output | 1 | One-cycle clear of the test-output select register |
| rx_acq_req | output | 1 | One-cycle request to start in acquisition mode |
| tx_path_rst | output | 1 | Transmit datapath reset |
| tx_flush | output | 1 | One-cycle transmit flush strobe |
| tx_start | output | 1 | One-cycle transmit re-enable strobe |
| osc_run | output | 1 | Oscillator enable |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser, a six-cycle receive flush and a one-cycle transmit flush. With these values the bench can try every pin/register combination on both paths. It also raises the receive enable at each of the six flush offsets, which covers both outcomes: release exactly at the end of the flush, and release delayed by synchroniser latency. Expected release cycles come from max(flush length, offset plus three).

// File: rtl/xcvr_pwr_pkg.sv
package xcvr_pwr_pkg;
  typedef enum logic [1:0] {
    PS_OFF = 2'd0,
    PS_SEQ = 2'd1,
    PS_ON  = 2'd2
  } pwr_state_e;

  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_RX_SEQ_LEN  = 6;
  localparam int unsigned DEF_TX_SEQ_LEN  = 1;
endpackage

// File: rtl/xcvr_en_sync.sv
module xcvr_en_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

  // R3: the last stage takes the previous value of the stage before it
  a_r3_sync_shift: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (chain[STAGES-1] == $past(chain[STAGES-2])));
endmodule

// File: rtl/xcvr_path_seq.sv
module xcvr_path_seq
  import xcvr_pwr_pkg::*;
#(
  parameter int unsigned SEQ_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  output logic path_rst,
  output logic seq_busy,
  output logic seq_first,
  output logic wake
);
  localparam int unsigned CW = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(SEQ_LEN - 1);

  pwr_state_e    state;
  logic [CW-1:0] cnt;
  logic          wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PS_OFF;
      cnt    <= '0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= 1'b0;
      unique case (state)
        PS_ON: begin
          if (!en_s) begin
            state <= PS_SEQ;
            cnt   <= '0;
          end
        end
        PS_SEQ: begin
          if (cnt == LAST) begin
            state  <= en_s ? PS_ON : PS_OFF;
            wake_q <= en_s;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (en_s) begin
            state  <= PS_ON;
            wake_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assign path_rst  = (state != PS_ON);
  assign seq_busy  = (state == PS_SEQ);
  assign seq_first = seq_busy && (cnt == '0);
  assign wake      = wake_q;

  // checker-side run length counter for the flush window
  localparam int unsigned RW = $clog2(SEQ_LEN + 2);
  logic [RW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (seq_busy) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  a_r4_flush_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_busy) |-> (run_q == RW'(SEQ_LEN)));
  a_r4_flush_in_rst: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> path_rst);
  a_r6_first_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
    seq_first |-> seq_busy);
  a_r5_stays_down: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(path_rst) && !$past(en_s)) |-> path_rst);
  a_r7_wake_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (!path_rst && $past(path_rst)));
endmodule

// File: rtl/xcvr_pwr_seq.sv
module xcvr_pwr_seq
  import xcvr_pwr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned RX_SEQ_LEN  = DEF_RX_SEQ_LEN,
  parameter int unsigned TX_SEQ_LEN  = DEF_TX_SEQ_LEN
) (
  input  logic rx_clk,
  input  logic tx_clk,
  input  logic rst_n,
  input  logic rx_en_pin,
  input  logic rx_en_reg,
  input  logic tx_en_pin,
  input  logic tx_en_reg,
  input  logic osc_en_reg,
  output logic rx_path_rst,
  output logic rx_flush,
  output logic tst_sel_clr,
  output logic rx_acq_req,
  output logic tx_path_rst,
  output logic tx_flush,
  output logic tx_start,
  output logic osc_run
);
  logic rx_en_raw, tx_en_raw;
  logic rx_en_s, tx_en_s;
  logic tx_busy;

  assign rx_en_raw = rx_en_pin | rx_en_reg;
  assign tx_en_raw = tx_en_pin | tx_en_reg;

  xcvr_en_sync #(.STAGES(SYNC_STAGES)) u_rx_sync (
    .clk(rx_clk), .rst_n(rst_n), .d(rx_en_raw), .q(rx_en_s)
  );

  xcvr_en_sync #(.STAGES(SYNC_STAGES)) u_tx_sync (
    .clk(tx_clk), .rst_n(rst_n), .d(tx_en_raw), .q(tx_en_s)
  );

  xcvr_path_seq #(.SEQ_LEN(RX_SEQ_LEN)) u_rx_seq (
    .clk(rx_clk), .rst_n(rst_n), .en_s(rx_en_s),
    .path_rst(rx_path_rst), .seq_busy(rx_flush),
    .seq_first(tst_sel_clr), .wake(rx_acq_req)
  );

  xcvr_path_seq #(.SEQ_LEN(TX_SEQ_LEN)) u_tx_seq (
    .clk(tx_clk), .rst_n(rst_n), .en_s(tx_en_s),
    .path_rst(tx_path_rst), .seq_busy(tx_busy),
    .seq_first(tx_flush), .wake(tx_start)
  );

  assign osc_run = osc_en_reg;

  // R8: a single-cycle transmit flush means busy and its first cycle coincide
  a_r8_tx_single: assert property (@(posedge tx_clk) disable iff (!rst_n)
    (TX_SEQ_LEN == 1) |-> (tx_busy == tx_flush));
  // R6: the test-select clear only happens with the receiver held in reset
  a_r6_clr_in_rst: assert property (@(posedge rx_clk) disable iff (!rst_n)
    tst_sel_clr |-> rx_path_rst);
  // R7: acquisition request only while the receiver is running
  a_r7_acq_running: assert property (@(posedge rx_clk) disable iff (!rst_n)
    rx_acq_req |-> !rx_path_rst);
endmodule

// File: tb/sim_xcvr_pwr_seq.sv
module sim_xcvr_pwr_seq;
  localparam int RX_HALF = 5;
  localparam int TX_HALF = 7;
  localparam int RX_LEN  = 6;

  logic rx_clk = 0, tx_clk = 0, rst_n = 0;
  logic rx_en_pin = 0, rx_en_reg = 0, tx_en_pin = 0, tx_en_reg = 0, osc_en_reg = 0;
  logic rx_path_rst, rx_flush, tst_sel_clr, rx_acq_req;
  logic tx_path_rst, tx_flush, tx_start, osc_run;

  int n_tests = 0, n_fail = 0, clr_count = 0;

  always #RX_HALF rx_clk = ~rx_clk;
  always #TX_HALF tx_clk = ~tx_clk;

  xcvr_pwr_seq u0 (.*);

  always @(negedge rx_clk) if (tst_sel_clr === 1'b1) clr_count++;

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic rxw(input int n); repeat (n) @(negedge rx_clk); endtask
  task automatic txw(input int n); repeat (n) @(negedge tx_clk); endtask

  // receive path is off; apply combination c and check release
  task automatic rx_up(input int c);
    rx_en_pin = c[0]; rx_en_reg = c[1];
    for (int j = 1; j <= 4; j++) begin
      rxw(1);
      chk("R1/R3 rx_path_rst", rx_path_rst, (j < 3) || (c == 0));
      chk("R7 rx_acq_req", rx_acq_req, (j == 3) && (c != 0));
    end
  endtask

  task automatic rx_down();
    rx_en_pin = 0; rx_en_reg = 0;
    rxw(2);
    chk("R3 rx still running", rx_path_rst, 1'b0);
    for (int j = 0; j < 9; j++) begin
      rxw(1);
      chk("R4 rx_flush", rx_flush, j < RX_LEN);
      chk("R5 rx_path_rst", rx_path_rst, 1'b1);
      chk("R6 tst_sel_clr", tst_sel_clr, j == 0);
      chk("R7 no acq", rx_acq_req, 1'b0);
    end
  endtask

  task automatic tx_up(input int c);
    tx_en_pin = c[0]; tx_en_reg = c[1];
    for (int j = 1; j <= 4; j++) begin
      txw(1);
      chk("R2/R3 tx_path_rst", tx_path_rst, (j < 3) || (c == 0));
      chk("R8 tx_start", tx_start, (j == 3) && (c != 0));
    end
  endtask

  task automatic tx_down();
    tx_en_pin = 0; tx_en_reg = 0;
    txw(2);
    chk("R8 tx still running", tx_path_rst, 1'b0);
    for (int j = 0; j < 4; j++) begin
      txw(1);
      chk("R8 tx_flush", tx_flush, j == 0);
      chk("R5 tx_path_rst", tx_path_rst, 1'b1);
    end
  endtask

  initial begin
    rxw(3);
    chk("R10 rx_path_rst", rx_path_rst, 1'b1);
    chk("R10 tx_path_rst", tx_path_rst, 1'b1);
    chk("R10 rx_flush", rx_flush, 1'b0);
    chk("R10 tst_sel_clr", tst_sel_clr, 1'b0);
    chk("R10 rx_acq_req", rx_acq_req, 1'b0);
    chk("R10 tx_flush", tx_flush, 1'b0);
    chk("R10 tx_start", tx_start, 1'b0);
    for (int v = 0; v < 2; v++) begin
      osc_en_reg = v[0]; #1;
      chk("R9 osc_run", osc_run, v[0]);
    end
    rst_n = 1;
    rxw(4);
    chk("R5 rx held after reset", rx_path_rst, 1'b1);

    // R1: all pin/register combinations
    for (int c = 0; c < 4; c++) begin
      rx_up(c);
      if (c != 0) rx_down();
      else begin
        rxw(5);
        chk("R1 both low stays off", rx_path_rst, 1'b1);
      end
    end

    // R7: enable rises at each flush offset
    for (int k = 0; k < RX_LEN; k++) begin
      rx_up(1);
      rx_en_pin = 0;
      rxw(2);
      for (int j = 0; j < 10; j++) begin
        int rel;
        rel = (k + 3 > RX_LEN) ? k + 3 : RX_LEN;
        rxw(1);
        chk("R4 mid flush", rx_flush, j < RX_LEN);
        chk("R7 release cycle", rx_path_rst, j < rel);
        chk("R7 acq cycle", rx_acq_req, j == rel);
        if (j == k) rx_en_pin = 1;
      end
      rx_en_pin = 0;
      rxw(3 + RX_LEN + 2);
    end

    // transmit path with receiver running; R6 no clear from tx
    rx_up(2);
    begin
      int clr0;
      clr0 = clr_count;
      for (int c = 0; c < 4; c++) begin
        tx_up(c);
        if (c != 0) tx_down();
        else begin
          txw(4);
          chk("R2 both low stays off", tx_path_rst, 1'b1);
        end
        osc_en_reg = c[0]; #1;
        chk("R9 osc independent", osc_run, c[0]);
      end
      chk("R6 no clear on tx shutdown", clr_count != clr0, 1'b0);
      chk("R6 rx untouched", rx_path_rst, 1'b0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(RX_HALF * 2 * 50000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule